// File: doc/BRIEF.md
# Windowed Multiplicity Coincidence Trigger

This block forms a trigger decision from forty board-level trigger lines, arranged as four crates of ten boards each. A rising edge on an enabled line opens a coincidence window. The block fires when the number of distinct lines that have risen inside that window reaches a programmable multiplicity. Only a line's first rising edge in a window is counted. Two complete settings exist, one for physics running and one for calibration running, and a single mode input selects which one applies. Each setting holds its own multiplicity and its own window length.

Every decision gives a one-cycle `decision` pulse and advances a 32-bit decision counter. It also starts a dead time, during which new edges are ignored. A delayed copy of the decision appears on `trig_out` unless the output was disabled at the moment of the decision. The counter still counts decisions made while the output is disabled, and a run-start strobe clears it. A veto input suppresses decisions.

All durations use one encoding: a setting `s` lasts `s + 2` clock cycles. With a 250 MHz core clock this is 4 ns per step plus 8 ns.

Top module: `coinc_trigger`

## Requirements
- R1: The block fires when the number of distinct enabled lines with a rising edge inside the open window is at least the selected multiplicity. A line that stays high, or that already counted in the window, adds nothing more.
- R2: Line bit index is crate*10 + board. A line whose bit in `line_en` is 0 never counts and never opens a window.
- R3: The window opens in the cycle of its first counted edge and lasts window setting + 2 cycles, that cycle included. An edge in its last cycle counts. An edge one cycle later starts a fresh window.
- R4: With `mode_cal` = 0 the physics multiplicity and window apply. With `mode_cal` = 1 the calibration pair applies.
- R5: A selected multiplicity of 0 never fires.
- R6: While `veto` is 1 no decision is made, and the counter does not move.
- R7: After a decision, `dead_active` is 1 for dead setting + 2 cycles. Edges arriving in those cycles are ignored. An edge in the first cycle after that can fire.
- R8: `decision` is a one-cycle pulse in the cycle after the firing edge. `trig_out` pulses once, delay setting + 2 cycles after `decision`.
- R9: `trig_out_en` is sampled at the decision. When it is 0, no `trig_out` pulse follows, but the decision is still counted.
- R10: `dec_count` rises by one with each decision. `run_start` clears it to 0, and the clear wins over a decision in the same cycle.
- R11: After reset, `decision`, `trig_out` and `dead_active` are 0 and `dec_count` is 0.
- R12: The delay holds one pending output. A decision made while an output is still pending produces no second `trig_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | 40 | Board trigger lines, bit crate*10+board |
| line_en | input | 40 | Per-line enable mask, same bit order |
| veto | input | 1 | Suppresses decisions while high |
| mode_cal | input | 1 | 0 selects physics settings, 1 calibration |
| mult_phys | input | 6 | Physics multiplicity (0..40) |
| mult_cal | input | 6 | Calibration multiplicity (0..40) |
| win_phys | input | 4 | Physics window setting |
| win_cal | input | 4 | Calibration window setting |
| delay_set | input | 16 | Decision-to-output delay setting |
| dead_set | input | 16 | Dead-time setting |
| trig_out_en | input | 1 | Enables the delayed trigger output |
| run_start | input | 1 | Clears the decision counter |
| decision | output | 1 | One-cycle decision pulse |
| trig_out | output | 1 | Delayed trigger pulse |
| dec_count | output | 32 | Decision counter |
| dead_active | output | 1 | High during dead time |

## Verification
The assertions assume that `run_start` stays low through reset. They also assume that the multiplicity inputs are not changed in the same cycle in which the checker relates them to `decision`. The bench changes all configuration only while the lines are low and idle, and it waits out every window, dead time and delay before it moves to the next case. Line stimulus consists of clean rising steps driven on the falling clock edge, so that every edge is seen in exactly one cycle.

// File: rtl/coinc_trigger_pkg.sv
package coinc_trigger_pkg;

    localparam int N_CRATES        = 4;
    localparam int LINES_PER_CRATE = 10;
    localparam int N_LINES         = N_CRATES * LINES_PER_CRATE;
    localparam int MULT_W          = $clog2(N_LINES + 1);
    localparam int WIN_W           = 4;
    localparam int DUR_W           = 16;
    localparam int CNT_W           = 32;
    localparam int FIXED_CYCLES    = 2;

    typedef enum logic {
        MODE_PHYS = 1'b0,
        MODE_CAL  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [WIN_W-1:0]  win;
    } coinc_cfg_t;

    // Pick the multiplicity/window pair for the active running mode.
    function automatic coinc_cfg_t pick_cfg(
        input trig_mode_e        mode,
        input logic [MULT_W-1:0] m_phys,
        input logic [WIN_W-1:0]  w_phys,
        input logic [MULT_W-1:0] m_cal,
        input logic [WIN_W-1:0]  w_cal
    );
        coinc_cfg_t c;
        if (mode == MODE_CAL) begin
            c.mult = m_cal;
            c.win  = w_cal;
        end else begin
            c.mult = m_phys;
            c.win  = w_phys;
        end
        return c;
    endfunction

    // Duration in cycles for a 16-bit setting: setting + fixed overhead.
    function automatic logic [DUR_W:0] dur_cycles(input logic [DUR_W-1:0] s);
        return {1'b0, s} + (DUR_W+1)'(FIXED_CYCLES);
    endfunction

endpackage

// File: rtl/coinc_edge_detect.sv
module coinc_edge_detect #(
    parameter int N_CRATES        = 4,
    parameter int LINES_PER_CRATE = 10,
    localparam int N_LINES        = N_CRATES * LINES_PER_CRATE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] enable,
    output logic [N_LINES-1:0] edges
);

    logic [N_LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    // One slice per crate; a line counts only where its enable bit is set.
    for (genvar c = 0; c < N_CRATES; c++) begin : g_crate
        localparam int LO = c * LINES_PER_CRATE;
        assign edges[LO +: LINES_PER_CRATE] =
            lines[LO +: LINES_PER_CRATE] &
            ~prev_q[LO +: LINES_PER_CRATE] &
            enable[LO +: LINES_PER_CRATE];
    end

endmodule

// File: rtl/coinc_window.sv
module coinc_window #(
    parameter int N_LINES = 40,
    parameter int MULT_W  = 6,
    parameter int WIN_W   = 4,
    localparam int REM_W  = WIN_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] edges,
    input  logic [MULT_W-1:0]  mult,
    input  logic [WIN_W-1:0]   win_set,
    input  logic               block,
    input  logic               veto,
    output logic               fire
);

    logic               win_act_q;
    logic [REM_W-1:0]   rem_q;
    logic [N_LINES-1:0] hits_q;
    logic [N_LINES-1:0] acc;
    logic [MULT_W-1:0]  hit_cnt;
    logic               live;

    // Lines seen so far in this window plus edges of this cycle.
    assign acc  = win_act_q ? (hits_q | edges) : edges;
    assign live = !block && (win_act_q || (|edges));

    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < N_LINES; i++)
            hit_cnt = hit_cnt + MULT_W'(acc[i]);
    end

    assign fire = live && !veto && (mult != '0) && (hit_cnt >= mult);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_act_q <= 1'b0;
            rem_q     <= '0;
            hits_q    <= '0;
        end else if (fire) begin
            win_act_q <= 1'b0;
            rem_q     <= '0;
            hits_q    <= '0;
        end else if (win_act_q) begin
            if (rem_q == REM_W'(1)) begin
                win_act_q <= 1'b0;
                rem_q     <= '0;
                hits_q    <= '0;
            end else begin
                rem_q  <= rem_q - REM_W'(1);
                hits_q <= acc;
            end
        end else if (live) begin
            // Window of win_set+2 cycles: this one plus win_set+1 more.
            win_act_q <= 1'b1;
            rem_q     <= {1'b0, win_set} + REM_W'(1);
            hits_q    <= edges;
        end
    end

endmodule

// File: rtl/coinc_dead_timer.sv
module coinc_dead_timer #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DUR_W:0]   length,
    output logic             active
);

    logic [DUR_W:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst)                rem_q <= '0;
        else if (start)         rem_q <= length;
        else if (rem_q != '0)   rem_q <= rem_q - (DUR_W+1)'(1);
    end

    assign active = (rem_q != '0);

endmodule

// File: rtl/coinc_delay_line.sv
module coinc_delay_line #(
    parameter int DUR_W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           launch,
    input  logic           out_en,
    input  logic [DUR_W:0] length,
    output logic           pulse
);

    logic           pend_q;
    logic [DUR_W:0] rem_q;
    logic           due;

    assign due = pend_q && (rem_q == (DUR_W+1)'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            rem_q  <= '0;
            pulse  <= 1'b0;
        end else begin
            pulse <= due;
            if (due) begin
                pend_q <= 1'b0;
            end else if (pend_q) begin
                rem_q <= rem_q - (DUR_W+1)'(1);
            end
            // Single slot: a launch is taken only when the slot is free.
            if (launch && out_en && (!pend_q || due)) begin
                pend_q <= 1'b1;
                rem_q  <= length;
            end
        end
    end

endmodule

// File: rtl/coinc_counter.sv
module coinc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else if (inc)     count <= count + CNT_W'(1);
    end

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
    import coinc_trigger_pkg::*;
#(
    parameter int P_CRATES      = N_CRATES,
    parameter int P_PER_CRATE   = LINES_PER_CRATE,
    parameter int P_WIN_W       = WIN_W,
    parameter int P_DUR_W       = DUR_W,
    parameter int P_CNT_W       = CNT_W,
    localparam int P_LINES      = P_CRATES * P_PER_CRATE,
    localparam int P_MULT_W     = $clog2(P_LINES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [P_LINES-1:0]  lines_in,
    input  logic [P_LINES-1:0]  line_en,
    input  logic                veto,
    input  logic                mode_cal,
    input  logic [P_MULT_W-1:0] mult_phys,
    input  logic [P_MULT_W-1:0] mult_cal,
    input  logic [P_WIN_W-1:0]  win_phys,
    input  logic [P_WIN_W-1:0]  win_cal,
    input  logic [P_DUR_W-1:0]  delay_set,
    input  logic [P_DUR_W-1:0]  dead_set,
    input  logic                trig_out_en,
    input  logic                run_start,
    output logic                decision,
    output logic                trig_out,
    output logic [P_CNT_W-1:0]  dec_count,
    output logic                dead_active
);

    logic [P_LINES-1:0] edges;
    logic               fire;
    coinc_cfg_t         cfg;
    logic [P_DUR_W:0]   dead_len;
    logic [P_DUR_W:0]   delay_len;

    assign cfg       = pick_cfg(trig_mode_e'(mode_cal), mult_phys, win_phys,
                                mult_cal, win_cal);
    assign dead_len  = {1'b0, dead_set}  + (P_DUR_W+1)'(FIXED_CYCLES);
    assign delay_len = {1'b0, delay_set} + (P_DUR_W+1)'(FIXED_CYCLES);

    coinc_edge_detect #(
        .N_CRATES        (P_CRATES),
        .LINES_PER_CRATE (P_PER_CRATE)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lines  (lines_in),
        .enable (line_en),
        .edges  (edges)
    );

    coinc_window #(
        .N_LINES (P_LINES),
        .MULT_W  (P_MULT_W),
        .WIN_W   (P_WIN_W)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .edges   (edges),
        .mult    (cfg.mult),
        .win_set (cfg.win),
        .block   (dead_active),
        .veto    (veto),
        .fire    (fire)
    );

    coinc_dead_timer #(
        .DUR_W (P_DUR_W)
    ) u_dead (
        .clk    (clk),
        .rst    (rst),
        .start  (fire),
        .length (dead_len),
        .active (dead_active)
    );

    coinc_delay_line #(
        .DUR_W (P_DUR_W)
    ) u_dly (
        .clk    (clk),
        .rst    (rst),
        .launch (fire),
        .out_en (trig_out_en),
        .length (delay_len),
        .pulse  (trig_out)
    );

    coinc_counter #(
        .CNT_W (P_CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (run_start),
        .inc   (fire),
        .count (dec_count)
    );

    always_ff @(posedge clk) begin
        if (rst) decision <= 1'b0;
        else     decision <= fire;
    end

endmodule

// File: rtl/coinc_trigger_chk.sv
module coinc_trigger_chk #(
    parameter int MULT_W = 6,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              veto,
    input logic              mode_cal,
    input logic [MULT_W-1:0] mult_phys,
    input logic [MULT_W-1:0] mult_cal,
    input logic              run_start,
    input logic              decision,
    input logic              trig_out,
    input logic              dec_count_nz,
    input logic [CNT_W-1:0]  dec_count,
    input logic              dead_active
);

    // R7: no decision can come out of a dead cycle
    a_r7_dead_blocks: assert property (@(posedge clk) disable iff (rst)
        dead_active |=> !decision);

    // R7: each decision is accompanied by the dead window starting
    a_r7_dead_follows: assert property (@(posedge clk) disable iff (rst)
        decision |-> dead_active);

    // R6: a vetoed cycle never yields a decision
    a_r6_veto: assert property (@(posedge clk) disable iff (rst)
        veto |=> !decision);

    // R5: zero multiplicity on the selected mode never fires
    a_r5_zero_mult: assert property (@(posedge clk) disable iff (rst)
        (((mode_cal ? mult_cal : mult_phys) == '0)) |=> !decision);

    // R8: decision and trigger output are single-cycle pulses
    a_r8_dec_pulse: assert property (@(posedge clk) disable iff (rst)
        decision |=> !decision);
    a_r8_out_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    // R10: counter steps by one per decision, holds otherwise, clears on run start
    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        (decision && !$past(run_start)) |-> (dec_count == $past(dec_count) + CNT_W'(1)));
    a_r10_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!decision && !$past(run_start)) |-> $stable(dec_count));
    a_r10_count_clear: assert property (@(posedge clk) disable iff (rst)
        $past(run_start) |-> !dec_count_nz);

endmodule

bind coinc_trigger coinc_trigger_chk #(
    .MULT_W (P_MULT_W),
    .CNT_W  (P_CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .veto         (veto),
    .mode_cal     (mode_cal),
    .mult_phys    (mult_phys),
    .mult_cal     (mult_cal),
    .run_start    (run_start),
    .decision     (decision),
    .trig_out     (trig_out),
    .dec_count_nz (|dec_count),
    .dec_count    (dec_count),
    .dead_active  (dead_active)
);

// File: tb/coinc_trigger_tb.sv
`timescale 1ns/1ps
module coinc_trigger_tb;

    localparam logic [39:0] ALL = 40'hFF_FFFF_FFFF;

    typedef struct packed {
        logic        mode;
        logic [5:0]  mult;
        logic [3:0]  win;
        logic [39:0] en;
        logic [39:0] a;
        logic [39:0] b;
        logic [7:0]  gap;
        logic        want;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd2,  4'd3,  ALL,              40'h1,        40'h8000,          8'd2, 1'b1}, // R1
        '{1'b0, 6'd3,  4'd3,  ALL,              40'h3,        40'h80_0000_0000,  8'd4, 1'b1}, // R3 last cycle
        '{1'b0, 6'd3,  4'd3,  ALL,              40'h3,        40'h80_0000_0000,  8'd5, 1'b0}, // R3 one late
        '{1'b0, 6'd3,  4'd3,  ALL,              40'h60,       40'h0,             8'd1, 1'b0}, // R1 distinct
        '{1'b0, 6'd2,  4'd3,  40'hFF_C00F_FFFF, 40'h30_0001,  40'h0,             8'd0, 1'b0}, // R2 crate 2 off
        '{1'b0, 6'd2,  4'd3,  40'h80_0000_0400, 40'h401,      40'h80_0000_0000,  8'd1, 1'b1}, // R2 mask
        '{1'b1, 6'd4,  4'd0,  ALL,              40'hF0,       40'h0,             8'd0, 1'b1}, // R4 cal
        '{1'b1, 6'd3,  4'd0,  ALL,              40'h2,        40'hC,             8'd1, 1'b1}, // R4 cal window
        '{1'b1, 6'd3,  4'd0,  ALL,              40'h2,        40'hC,             8'd2, 1'b0}, // R4 cal window late
        '{1'b0, 6'd0,  4'd3,  ALL,              ALL,          40'h0,             8'd0, 1'b0}, // R5
        '{1'b0, 6'd40, 4'd3,  ALL,              ALL,          40'h0,             8'd0, 1'b1}, // R1 full
        '{1'b0, 6'd1,  4'd15, ALL,              40'h80,       40'h0,             8'd0, 1'b1}  // R1 single
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [39:0] lines_in = '0;
    logic [39:0] line_en = ALL;
    logic        veto = 1'b0;
    logic        mode_cal = 1'b0;
    logic [5:0]  mult_phys = 6'd1;
    logic [5:0]  mult_cal = 6'd1;
    logic [3:0]  win_phys = '0;
    logic [3:0]  win_cal = '0;
    logic [15:0] delay_set = '0;
    logic [15:0] dead_set = '0;
    logic        trig_out_en = 1'b1;
    logic        run_start = 1'b0;
    logic        decision;
    logic        trig_out;
    logic [31:0] dec_count;
    logic        dead_active;

    int checks = 0;
    int fails = 0;
    int n_dec = 0;
    int n_trig = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    coinc_trigger u_dut (
        .clk         (clk),
        .rst         (rst),
        .lines_in    (lines_in),
        .line_en     (line_en),
        .veto        (veto),
        .mode_cal    (mode_cal),
        .mult_phys   (mult_phys),
        .mult_cal    (mult_cal),
        .win_phys    (win_phys),
        .win_cal     (win_cal),
        .delay_set   (delay_set),
        .dead_set    (dead_set),
        .trig_out_en (trig_out_en),
        .run_start   (run_start),
        .decision    (decision),
        .trig_out    (trig_out),
        .dec_count   (dec_count),
        .dead_active (dead_active)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (decision) n_dec++;
            if (trig_out) n_trig++;
        end
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint want);
        checks++;
        if (act != want) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, want);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        lines_in = '0;
        tick(n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int d0, t0;
        logic [31:0] c0;
        tick(5);
        rst = 1'b0;
        tick(1);
        // R11: reset state
        check("R11", "decision", decision, 0);
        check("R11", "trig_out", trig_out, 0);
        check("R11", "dec_count", dec_count, 0);
        check("R11", "dead_active", dead_active, 0);

        // Table of coincidence cases
        for (int v = 0; v < NV; v++) begin
            idle(3);
            mode_cal = VEC[v].mode;
            line_en  = VEC[v].en;
            if (VEC[v].mode) begin
                mult_cal  = VEC[v].mult;  win_cal  = VEC[v].win;
                mult_phys = VEC[v].want ? 6'd40 : 6'd1; win_phys = 4'd0;
            end else begin
                mult_phys = VEC[v].mult;  win_phys = VEC[v].win;
                mult_cal  = VEC[v].want ? 6'd40 : 6'd1; win_cal  = 4'd0;
            end
            tick(2);
            d0 = n_dec; t0 = n_trig; c0 = dec_count;
            if (VEC[v].gap == 0) begin
                lines_in = VEC[v].a | VEC[v].b;
            end else begin
                lines_in = VEC[v].a;
                tick(int'(VEC[v].gap));
                lines_in = VEC[v].a | VEC[v].b;
            end
            tick(40);
            check(v < 6 ? "R1/R2/R3" : "R4/R5/R1", $sformatf("vector %0d decisions", v),
                  n_dec - d0, VEC[v].want);
            check("R8", $sformatf("vector %0d outputs", v), n_trig - t0, VEC[v].want);
            check("R10", $sformatf("vector %0d count", v), dec_count - c0, VEC[v].want);
        end

        // R8: exact decision and output timing, delay setting 3 -> 5 cycles
        idle(3);
        mode_cal = 1'b0; mult_phys = 6'd1; win_phys = 4'd2; line_en = ALL;
        delay_set = 16'd3; dead_set = 16'd0;
        tick(3);
        lines_in = 40'h1;
        tick(1); check("R8", "decision at +1", decision, 1);
        tick(1); check("R8", "decision at +2", decision, 0);
        tick(3); check("R8", "trig_out at +5", trig_out, 0);
        tick(1); check("R8", "trig_out at +6", trig_out, 1);
        tick(1); check("R8", "trig_out at +7", trig_out, 0);

        // R7: dead setting 5 -> 7 dead cycles
        idle(20);
        delay_set = 16'd0; dead_set = 16'd5;
        tick(2);
        lines_in = 40'h1;
        tick(7);
        check("R7", "dead_active at +7", dead_active, 1);
        lines_in = 40'h3;
        tick(1);
        check("R7", "edge in dead ignored", decision, 0);
        check("R7", "dead_active at +8", dead_active, 0);
        lines_in = 40'h7;
        tick(1);
        check("R7", "edge after dead fires", decision, 1);

        // R6: veto suppresses
        idle(20);
        dead_set = 16'd0; veto = 1'b1;
        tick(2);
        d0 = n_dec; c0 = dec_count;
        lines_in = 40'h20;
        tick(10);
        check("R6", "vetoed decisions", n_dec - d0, 0);
        check("R6", "vetoed count", dec_count - c0, 0);
        idle(5);
        veto = 1'b0;

        // R9: output disabled, decision still counted
        trig_out_en = 1'b0;
        tick(2);
        d0 = n_dec; t0 = n_trig; c0 = dec_count;
        lines_in = 40'h8;
        tick(10);
        check("R9", "decisions with output off", n_dec - d0, 1);
        check("R9", "outputs with output off", n_trig - t0, 0);
        check("R9", "count with output off", dec_count - c0, 1);
        idle(5);
        trig_out_en = 1'b1;

        // R10: clear wins over a same-cycle decision
        tick(2);
        run_start = 1'b1;
        lines_in = 40'h1;
        tick(1);
        run_start = 1'b0;
        check("R10", "decision during clear", decision, 1);
        check("R10", "count after clear", dec_count, 0);
        tick(5);
        lines_in = 40'h3;
        tick(3);
        check("R10", "count after next decision", dec_count, 1);

        // R12: second decision while an output is pending, delay 18 -> 20
        idle(10);
        delay_set = 16'd18; dead_set = 16'd0;
        tick(30);
        d0 = n_dec; t0 = n_trig;
        lines_in = 40'h1;
        tick(5);
        lines_in = 40'h3;
        tick(16);
        check("R12", "first output at +21", trig_out, 1);
        tick(25);
        check("R12", "decisions", n_dec - d0, 2);
        check("R12", "outputs", n_trig - t0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule